// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block owns the processor status word and the five banked saved-status registers of a 32-bit core. It decides which exception to take when requests arrive, and carries out the entry in one clock edge. On that edge it switches the mode field and sets the interrupt masks. It also saves the old status into the bank of the new mode and emits a link-register write carrying the next-instruction address. It loads the program counter with the vector address. It also carries out the exception return, which restores the status word from the saved copy of the active mode.

Software can read either status word combinationally and can write either one with a per-byte enable mask. A saved-status access made from a mode without a bank does nothing. All outputs are registered. An entry accepted at a rising edge is visible on the outputs after that edge. The general register file, decode and memory interface sit outside this block.

Top module: `exc_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the status word becomes 0x000000D3. This is supervisor mode 5'b10011 with bit 7 (IRQ mask) and bit 6 (FIQ mask) set. All saved-status banks clear to zero, and after the edge `pc_we` is 1 with `pc_vec` equal to `VEC_BASE`.
- R2: An accepted request sets status bits [4:0] to the mode of its cause and loads `pc_vec` = `VEC_BASE` + offset. The pairs are: data abort 10111/0x10, FIQ 10001/0x1C, IRQ 10010/0x18, prefetch abort 10111/0x0C, undefined 11011/0x04, software interrupt 10011/0x08.
- R3: On entry, `lr_we` pulses for one cycle with `lr_mode` equal to the new mode and `lr_data` equal to `next_pc` as sampled at the entry edge.
- R4: On entry, the status word held before the edge is written into the saved-status bank of the new mode. It is also presented on `spsr_data`, with `spsr_we` high and `spsr_mode` equal to the new mode.
- R5: Every entry sets status bit 7. Only an FIQ entry sets bit 6; other entries leave bit 6 and bits [31:8] and bit 5 unchanged.
- R6: Simultaneous requests are served in the order data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt; only one is taken per cycle and the rest are dropped.
- R7: An IRQ request is ignored while status bit 7 is set, and an FIQ request while bit 6 is set.
- R8: `ret_req` copies the saved-status bank of the active mode into the status word. In user (10000), system (11111) or any mode without a bank it has no effect.
- R9: With `psr_wr_en` high and `psr_wr_spsr` low, each byte i of the status word for which `psr_wr_mask[i]` is 1 takes byte i of `psr_wr_data`. `psr_rd_data` shows the status word while `psr_rd_spsr` is 0, and the active mode's saved status while it is 1.
- R10: With `psr_wr_spsr` high, the same masked write goes to the bank of the active mode. In a mode without a bank the write is discarded and the saved-status read returns 0.
- R11: An accepted entry takes precedence over `ret_req`, which takes precedence over a software write. The lower-ranked operations in the same cycle are discarded.
- R12: In cycles with no entry and no reset, `pc_we`, `lr_we` and `spsr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts as reset exception |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined instruction request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| next_pc | input | ADDR_W | Address of the instruction after the faulting one |
| ret_req | input | 1 | Exception return request |
| psr_wr_en | input | 1 | Software status write strobe |
| psr_wr_spsr | input | 1 | Write target: 0 status word, 1 saved status |
| psr_wr_mask | input | 4 | Byte enables of the software write |
| psr_wr_data | input | 32 | Software write data |
| psr_rd_spsr | input | 1 | Read select: 0 status word, 1 saved status |
| psr_rd_data | output | 32 | Read data |
| cpsr_o | output | 32 | Current status word |
| lr_we | output | 1 | Banked link-register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | ADDR_W | Link value |
| spsr_we | output | 1 | Saved-status write strobe on entry |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_data | output | 32 | Saved value |
| pc_we | output | 1 | Program counter load strobe |
| pc_vec | output | ADDR_W | Vector address |

## Verification
The bench builds the block with `ADDR_W` = 32 and `VEC_BASE` = 0xFFFF0000, so that a missing base addition or a wrong vector offset shows in the upper and lower address bits at once. The directed part covers nested FIQ-inside-IRQ entry and return and masked interrupt requests. It also covers saved-status accesses from user mode and same-cycle collisions of entry, return and write. A random phase then drives all requests, returns and masked writes together. Random writes can leave the mode field on codes without a bank, which exercises the discard paths.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PSR_W  = 32;
    localparam int MASK_W = PSR_W / 8;
    localparam int N_BANK = 5;
    localparam int N_SRC  = 6;

    localparam int BIT_IMASK = 7;
    localparam int BIT_FMASK = 6;

    typedef enum logic [4:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    // index order equals service priority, 0 first
    typedef enum logic [2:0] {
        C_DABT = 3'd0,
        C_FIQ  = 3'd1,
        C_IRQ  = 3'd2,
        C_PABT = 3'd3,
        C_UND  = 3'd4,
        C_SWI  = 3'd5,
        C_NONE = 3'd7
    } cause_e;

    typedef struct packed {
        logic   valid;
        cause_e cause;
        mode_e  mode;
        logic [7:0] offset;
    } grant_t;

    localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

    function automatic mode_e cause_mode(cause_e c);
        case (c)
            C_DABT, C_PABT: return M_ABT;
            C_FIQ:          return M_FIQ;
            C_IRQ:          return M_IRQ;
            C_UND:          return M_UND;
            default:        return M_SVC;
        endcase
    endfunction

    function automatic logic [7:0] cause_offset(cause_e c);
        case (c)
            C_DABT:  return 8'h10;
            C_FIQ:   return 8'h1C;
            C_IRQ:   return 8'h18;
            C_PABT:  return 8'h0C;
            C_UND:   return 8'h04;
            C_SWI:   return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [4:0] bank_mode(int idx);
        case (idx)
            0:       return M_FIQ;
            1:       return M_IRQ;
            2:       return M_SVC;
            3:       return M_ABT;
            default: return M_UND;
        endcase
    endfunction

    function automatic logic has_bank(logic [4:0] m);
        return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
    endfunction

    function automatic logic [PSR_W-1:0] byte_merge(
        logic [PSR_W-1:0] old_v, logic [PSR_W-1:0] new_v, logic [MASK_W-1:0] en);
        logic [PSR_W-1:0] r;
        r = old_v;
        for (int i = 0; i < MASK_W; i++)
            if (en[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_dabt,
    input  logic   req_fiq,
    input  logic   req_irq,
    input  logic   req_pabt,
    input  logic   req_und,
    input  logic   req_swi,
    input  logic   imask,
    input  logic   fmask,
    output grant_t gnt
);
    logic [N_SRC-1:0] req_v;
    logic [N_SRC-1:0] hot;

    assign req_v = {req_swi, req_und, req_pabt, req_irq & ~imask,
                    req_fiq & ~fmask, req_dabt};

    always_comb begin
        logic taken;
        taken = 1'b0;
        hot   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_v[i] && !taken) begin
                hot[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    always_comb begin
        gnt.valid = |hot;
        gnt.cause = C_NONE;
        for (int i = N_SRC - 1; i >= 0; i--)
            if (hot[i]) gnt.cause = cause_e'(i[2:0]);
        gnt.mode   = cause_mode(gnt.cause);
        gnt.offset = cause_offset(gnt.cause);
    end

    assert_onehot_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hot));
    assert_fiq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        fmask |-> !hot[1]);
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        imask |-> !hot[2]);

endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [4:0]       wr_mode,
    input  logic [PSR_W-1:0] wr_data,
    input  logic [4:0]       rd_mode,
    output logic [PSR_W-1:0] rd_data,
    output logic             rd_hit
);
    logic [PSR_W-1:0] bank_q [N_BANK];
    logic [N_BANK-1:0] sel_rd;

    for (genvar i = 0; i < N_BANK; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[i] <= '0;
            else if (wr_en && wr_mode == bank_mode(i))
                bank_q[i] <= wr_data;
        end
        assign sel_rd[i] = (rd_mode == bank_mode(i));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_BANK; i++)
            if (sel_rd[i]) rd_data = bank_q[i];
    end

    assign rd_hit = |sel_rd;

    assert_bank_target_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> has_bank(wr_mode));

endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_swi,
    input  logic              req_und,
    input  logic              req_pabt,
    input  logic              req_dabt,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              ret_req,
    input  logic              psr_wr_en,
    input  logic              psr_wr_spsr,
    input  logic [3:0]        psr_wr_mask,
    input  logic [31:0]       psr_wr_data,
    input  logic              psr_rd_spsr,
    output logic [31:0]       psr_rd_data,
    output logic [31:0]       cpsr_o,
    output logic              lr_we,
    output logic [4:0]        lr_mode,
    output logic [ADDR_W-1:0] lr_data,
    output logic              spsr_we,
    output logic [4:0]        spsr_mode,
    output logic [31:0]       spsr_data,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_vec
);
    logic [PSR_W-1:0] cpsr_q, cpsr_nx;
    grant_t           gnt;
    logic [PSR_W-1:0] bank_rd;
    logic             bank_hit;
    logic             bank_we;
    logic [4:0]       bank_wmode;
    logic [PSR_W-1:0] bank_wdata;
    logic             do_entry, do_ret, do_wr_cpsr, do_wr_spsr;

    exc_prio_arb u_arb (
        .clk(clk), .rst(rst),
        .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
        .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
        .imask(cpsr_q[BIT_IMASK]), .fmask(cpsr_q[BIT_FMASK]),
        .gnt(gnt)
    );

    exc_spsr_bank u_bank (
        .clk(clk), .rst(rst),
        .wr_en(bank_we), .wr_mode(bank_wmode), .wr_data(bank_wdata),
        .rd_mode(cpsr_q[4:0]), .rd_data(bank_rd), .rd_hit(bank_hit)
    );

    // precedence: entry, then return, then software write
    always_comb begin
        do_entry   = gnt.valid;
        do_ret     = !do_entry && ret_req && bank_hit;
        do_wr_cpsr = !do_entry && !ret_req && psr_wr_en && !psr_wr_spsr;
        do_wr_spsr = !do_entry && !ret_req && psr_wr_en && psr_wr_spsr && bank_hit;
    end

    always_comb begin
        cpsr_nx = cpsr_q;
        if (do_entry) begin
            cpsr_nx[4:0]       = gnt.mode;
            cpsr_nx[BIT_IMASK] = 1'b1;
            if (gnt.cause == C_FIQ) cpsr_nx[BIT_FMASK] = 1'b1;
        end else if (do_ret) begin
            cpsr_nx = bank_rd;
        end else if (do_wr_cpsr) begin
            cpsr_nx = byte_merge(cpsr_q, psr_wr_data, psr_wr_mask);
        end
    end

    always_comb begin
        bank_we    = do_entry || do_wr_spsr;
        bank_wmode = do_entry ? gnt.mode : cpsr_q[4:0];
        bank_wdata = do_entry ? cpsr_q : byte_merge(bank_rd, psr_wr_data, psr_wr_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpsr_q    <= PSR_RESET;
            pc_we     <= 1'b1;
            pc_vec    <= VEC_BASE;
            lr_we     <= 1'b0;
            lr_mode   <= M_SVC;
            lr_data   <= '0;
            spsr_we   <= 1'b0;
            spsr_mode <= M_SVC;
            spsr_data <= '0;
        end else begin
            cpsr_q    <= cpsr_nx;
            pc_we     <= do_entry;
            pc_vec    <= VEC_BASE + ADDR_W'(gnt.offset);
            lr_we     <= do_entry;
            lr_mode   <= gnt.mode;
            lr_data   <= next_pc;
            spsr_we   <= do_entry;
            spsr_mode <= gnt.mode;
            spsr_data <= cpsr_q;
        end
    end

    assign cpsr_o      = cpsr_q;
    assign psr_rd_data = psr_rd_spsr ? bank_rd : cpsr_q;

    assert_entry_imask_R5: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> cpsr_q[BIT_IMASK]);
    assert_fiq_fmask_R5: assert property (@(posedge clk) disable iff (rst)
        (lr_we && lr_mode == M_FIQ) |-> cpsr_q[BIT_FMASK]);
    assert_lr_mode_R3: assert property (@(posedge clk) disable iff (rst)
        lr_we |-> (lr_mode == cpsr_q[4:0]));
    assert_save_with_link_R4: assert property (@(posedge clk) disable iff (rst)
        lr_we |-> (spsr_we && spsr_mode == lr_mode && pc_we));
    assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!do_entry) |=> !lr_we);

endmodule

// File: tb/sim_exc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_exc_mode_ctrl;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic clk = 1'b0;
    logic rst;
    logic req_swi, req_und, req_pabt, req_dabt, req_irq, req_fiq;
    logic [AW-1:0] next_pc;
    logic ret_req, psr_wr_en, psr_wr_spsr, psr_rd_spsr;
    logic [3:0] psr_wr_mask;
    logic [31:0] psr_wr_data, psr_rd_data, cpsr_o, spsr_data;
    logic lr_we, spsr_we, pc_we;
    logic [4:0] lr_mode, spsr_mode;
    logic [AW-1:0] lr_data, pc_vec;

    always #10 clk = ~clk;

    exc_mode_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst(rst),
        .req_swi(req_swi), .req_und(req_und), .req_pabt(req_pabt),
        .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
        .next_pc(next_pc), .ret_req(ret_req),
        .psr_wr_en(psr_wr_en), .psr_wr_spsr(psr_wr_spsr),
        .psr_wr_mask(psr_wr_mask), .psr_wr_data(psr_wr_data),
        .psr_rd_spsr(psr_rd_spsr), .psr_rd_data(psr_rd_data),
        .cpsr_o(cpsr_o), .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
        .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data),
        .pc_we(pc_we), .pc_vec(pc_vec)
    );

    // behavioural reference state
    int unsigned errors = 0;
    int unsigned checks = 0;
    string       tag = "R1";
    bit          done = 0;
    logic [31:0] m_cpsr;
    logic [31:0] m_saved [32];
    logic        e_pulse;
    logic [4:0]  e_mode;
    logic [31:0] e_vec, e_lr, e_sd;

    function automatic bit banked(logic [4:0] m);
        int v = int'(m);
        return v == 17 || v == 18 || v == 19 || v == 23 || v == 27;
    endfunction

    function automatic logic [31:0] mix(logic [31:0] o, logic [31:0] n, logic [3:0] k);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (k[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic model_edge();
        int c;
        logic [4:0] cm;
        if (rst) begin
            m_cpsr = 32'h0000_00D3;
            for (int i = 0; i < 32; i++) m_saved[i] = '0;
            e_pulse = 0;
            e_vec = BASE;
            return;
        end
        cm = m_cpsr[4:0];
        c = -1;
        if (req_dabt) c = 0;
        else if (req_fiq && !m_cpsr[6]) c = 1;
        else if (req_irq && !m_cpsr[7]) c = 2;
        else if (req_pabt) c = 3;
        else if (req_und) c = 4;
        else if (req_swi) c = 5;
        e_pulse = (c >= 0);
        if (c >= 0) begin
            case (c)
                0: begin e_mode = 5'h17; e_vec = BASE + 32'h10; end
                1: begin e_mode = 5'h11; e_vec = BASE + 32'h1C; end
                2: begin e_mode = 5'h12; e_vec = BASE + 32'h18; end
                3: begin e_mode = 5'h17; e_vec = BASE + 32'h0C; end
                4: begin e_mode = 5'h1B; e_vec = BASE + 32'h04; end
                default: begin e_mode = 5'h13; e_vec = BASE + 32'h08; end
            endcase
            e_lr = next_pc;
            e_sd = m_cpsr;
            m_saved[e_mode] = m_cpsr;
            m_cpsr[4:0] = e_mode;
            m_cpsr[7] = 1'b1;
            if (c == 1) m_cpsr[6] = 1'b1;
        end else if (ret_req) begin
            if (banked(cm)) m_cpsr = m_saved[cm];
        end else if (psr_wr_en) begin
            if (!psr_wr_spsr) m_cpsr = mix(m_cpsr, psr_wr_data, psr_wr_mask);
            else if (banked(cm)) m_saved[cm] = mix(m_saved[cm], psr_wr_data, psr_wr_mask);
        end
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] rd_exp;
        chk("cpsr", cpsr_o, m_cpsr);
        chk("pc_we", 32'(pc_we), 32'(e_pulse || rst));
        chk("lr_we", 32'(lr_we), 32'(e_pulse));
        chk("spsr_we", 32'(spsr_we), 32'(e_pulse));
        if (e_pulse || rst) chk("pc_vec", pc_vec, e_vec);
        if (e_pulse) begin
            chk("lr_mode", 32'(lr_mode), 32'(e_mode));
            chk("lr_data", lr_data, e_lr);
            chk("spsr_mode", 32'(spsr_mode), 32'(e_mode));
            chk("spsr_data", spsr_data, e_sd);
        end
        if (psr_rd_spsr) rd_exp = banked(m_cpsr[4:0]) ? m_saved[m_cpsr[4:0]] : 32'h0;
        else             rd_exp = m_cpsr;
        chk("rd_data", psr_rd_data, rd_exp);
    endtask

    task automatic idle_in();
        {req_swi, req_und, req_pabt, req_dabt, req_irq, req_fiq} = '0;
        ret_req = 0; psr_wr_en = 0; psr_wr_spsr = 0; psr_wr_mask = '0;
        psr_wr_data = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        idle_in();
    endtask

    task automatic wr(bit to_saved, logic [3:0] k, logic [31:0] d);
        psr_wr_en = 1; psr_wr_spsr = to_saved; psr_wr_mask = k; psr_wr_data = d;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle_in();
        psr_rd_spsr = 0;
        next_pc = 32'h0000_1000;
        rst = 1;
        @(negedge clk);
        tag = "R1";
        cyc(); cyc();
        rst = 0;
        tag = "R12";
        cyc(); cyc();

        tag = "R9";   // to user mode with flags set, masks open
        wr(0, 4'b1001, 32'hF0AB_CD10);
        psr_rd_spsr = 0; cyc();

        tag = "R10";  // saved-status access from user mode
        wr(1, 4'hF, 32'h1234_5678);
        psr_rd_spsr = 1; cyc();
        psr_rd_spsr = 0;
        tag = "R8";   // return from user mode
        ret_req = 1; cyc();

        tag = "R3";   // software interrupt
        next_pc = 32'h0000_2468; req_swi = 1; cyc();
        tag = "R4";
        psr_rd_spsr = 1; cyc(); psr_rd_spsr = 0;
        tag = "R10";  // saved-status write in a banked mode
        wr(1, 4'b0010, 32'h0000_5500);
        psr_rd_spsr = 1; cyc(); psr_rd_spsr = 0;
        tag = "R8";
        ret_req = 1; cyc();

        tag = "R5";   // IRQ then nested FIQ
        next_pc = 32'h0000_3000; req_irq = 1; cyc();
        tag = "R7";
        req_irq = 1; cyc();
        tag = "R5";
        next_pc = 32'h0000_3004; req_fiq = 1; cyc();
        tag = "R7";
        req_fiq = 1; req_irq = 1; cyc();
        tag = "R8";
        ret_req = 1; cyc();
        ret_req = 1; cyc();

        tag = "R6";
        {req_swi, req_und, req_pabt, req_dabt, req_irq, req_fiq} = '1; cyc();
        ret_req = 1; cyc();
        req_fiq = 1; req_irq = 1; req_pabt = 1; cyc();
        ret_req = 1; cyc();
        req_irq = 1; req_pabt = 1; req_swi = 1; cyc();
        ret_req = 1; cyc();
        req_und = 1; req_swi = 1; cyc();
        ret_req = 1; cyc();
        req_pabt = 1; req_und = 1; cyc();
        ret_req = 1; cyc();

        tag = "R2";
        req_dabt = 1; cyc(); ret_req = 1; cyc();
        req_und = 1; cyc(); ret_req = 1; cyc();

        tag = "R11";
        req_swi = 1; ret_req = 1; psr_wr_en = 1; psr_wr_mask = 4'hF;
        psr_wr_data = 32'h0000_0010; cyc();
        ret_req = 1; psr_wr_en = 1; psr_wr_mask = 4'hF; psr_wr_data = 32'h0000_001F;
        cyc();

        tag = "R12";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            req_dabt = (r[3:0] == 0); req_fiq = (r[7:4] < 2);
            req_irq = (r[11:8] < 3); req_pabt = (r[15:12] == 1);
            req_und = (r[19:16] == 2); req_swi = (r[23:20] == 3);
            ret_req = (r[27:24] < 4);
            psr_wr_en = r[28]; psr_wr_spsr = r[29]; psr_wr_mask = 4'($urandom);
            psr_wr_data = $urandom;
            if (r[30]) psr_wr_data[4:0] = 5'h10;
            psr_rd_spsr = r[31];
            next_pc = $urandom;
            cyc();
        end
        psr_rd_spsr = 0;
        finish_run();
    end
endmodule